// File: doc/BRIEF.md
# Floppy Controller Phase and Main Status Sequencer

This block follows a floppy-style disk controller through the life of each command and produces the 8-bit main status value that the host polls before it touches the data register. A command starts when the host writes an opcode byte while the block is idle. The block then takes a fixed number of parameter bytes, may wait in an execution phase until the execution engine reports completion, and hands out a fixed number of result bytes before it returns to idle. A small opcode table sets the byte counts for each command. The status handshake bits always tell the host whether it may move a byte and in which direction.

The block also keeps a busy flag for each drive. A flag is raised when that drive starts a seek and stays raised after the seek finishes. It drops only when the host reads the first result byte of a Sense Interrupt command that reports that drive. A read or write command aimed at a busy drive is turned away on its drive-select byte. Reading the status value never changes any state. Only data-register strobes, the execution-done pulse and the seek inputs move the block forward.

Top module: `fdc_phase_seq`

## Requirements
- R1: Status layout: bit 7 = request (host may access data register), bit 6 = direction (1 = controller to host), bit 5 = execution flag, bit 4 = controller busy, bits 3..0 = busy flags of drives 3..0. After reset the status is 0x80, the phase is 0 and the result gate is 0.
- R2: Phase codes are idle = 0, command = 1, execution = 2, result = 3. The order is idle, then command, then execution, then result, then idle again. Each accepted data-register write in idle or command advances the sequence by one byte. The phase returns to idle on the read of the last result byte.
- R3: Request and direction follow the phase. In idle and command, request = 1 and direction = 0. In execution, request = 0. In result, request = 1 and direction = 1. The result gate output is 1 only in the result phase.
- R4: The execution flag is 1 only in the execution phase while dma_mode is 0. It is 0 in all other cases, and it follows dma_mode within the execution phase.
- R5: Controller busy is 1 whenever the phase is not idle. Data-register writes in the execution or result phase are ignored. Data-register reads outside the result phase are ignored.
- R6: The whole first byte selects the command. 0x06 (read) and 0x05 (write) take 8 parameters, an execution phase and 7 result bytes. 0x0F (seek) takes 2 parameters, no execution phase and no results. 0x08 (sense interrupt) takes no parameters and gives 2 result bytes. Any other byte takes no parameters and gives 1 result byte.
- R7: seek_start[i] sets drive i's busy flag. The flag stays set through seek_done[i] until a sense interrupt clears it.
- R8: For a read or write, if bits 1..0 of the first parameter byte name a busy drive, the command is refused and the phase returns to idle on that byte.
- R9: When a sense interrupt opcode is accepted, it selects the lowest-numbered drive that is busy and whose seek has finished. The first result-byte read clears that drive's flag. Drives still seeking are left unchanged, and later reads clear nothing.
- R10: The status output depends only on the current state and dma_mode. With no strobes it holds its value cycle after cycle.
- R11: An exec_done pulse in the execution phase moves the phase to result, or to idle if the command has zero results. exec_done in any other phase is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dr_wr | input | 1 | Host write strobe to the data register |
| dr_wdata | input | 8 | Byte written by the host |
| dr_rd | input | 1 | Host read strobe from the data register |
| dma_mode | input | 1 | 1 selects DMA transfer mode |
| exec_done | input | 1 | Completion pulse from the execution engine |
| seek_start | input | NUM_DRIVES | Per-drive seek start pulse |
| seek_done | input | NUM_DRIVES | Per-drive seek finished pulse |
| status_o | output | 8 | Main status value |
| phase_o | output | 2 | Current phase code |
| rslt_gate_o | output | 1 | Enables result-byte reads |

## Verification
The bench builds the block with its defaults: four drives and a 4-bit byte counter. With four drives, every busy bit of the status byte is driven by a real flag. The refusal path can then be tested on one drive while two other drives stand at different stages of a seek. This covers a sense interrupt that finds no finished drive, as well as one that picks the lowest finished drive while a higher drive keeps seeking. The 4-bit counter holds the eight-parameter, seven-result commands, so their full byte counts run end to end in both DMA and non-DMA execution.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_EXEC = 2'd2,
    PH_RSLT = 2'd3
  } phase_e;

  localparam logic [7:0] OP_READ  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h05;
  localparam logic [7:0] OP_SEEK  = 8'h0F;
  localparam logic [7:0] OP_SENSE = 8'h08;

  typedef struct packed {
    logic [CNT_W-1:0] n_param;
    logic [CNT_W-1:0] n_rslt;
    logic             has_exec;
    logic             chk_busy;
    logic             is_sense;
  } cmd_info_t;

  // Opcode table: byte counts and behaviour flags per command.
  function automatic cmd_info_t cmd_lookup(input logic [7:0] op);
    cmd_info_t ci;
    ci = '0;
    case (op)
      OP_READ, OP_WRITE: begin
        ci.n_param  = CNT_W'(8);
        ci.n_rslt   = CNT_W'(7);
        ci.has_exec = 1'b1;
        ci.chk_busy = 1'b1;
      end
      OP_SEEK: begin
        ci.n_param  = CNT_W'(2);
      end
      OP_SENSE: begin
        ci.n_rslt   = CNT_W'(2);
        ci.is_sense = 1'b1;
      end
      default: begin
        ci.n_rslt   = CNT_W'(1);
      end
    endcase
    return ci;
  endfunction

  // Phase entered once the last parameter byte has been taken.
  function automatic phase_e after_params(input cmd_info_t ci);
    if (ci.has_exec)       return PH_EXEC;
    else if (ci.n_rslt != '0) return PH_RSLT;
    else                   return PH_IDLE;
  endfunction

  // Main status byte assembly.
  function automatic logic [7:0] make_status(input phase_e ph, input logic dma,
                                             input logic [3:0] busy4);
    logic rqm, dio, exm, cb;
    rqm = (ph != PH_EXEC);
    dio = (ph == PH_RSLT);
    exm = (ph == PH_EXEC) && !dma;
    cb  = (ph != PH_IDLE);
    return {rqm, dio, exm, cb, busy4};
  endfunction

endpackage

// File: rtl/fdc_phase_fsm.sv
module fdc_phase_fsm
  import fdc_seq_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dr_wr,
  input  logic [7:0]            dr_wdata,
  input  logic                  dr_rd,
  input  logic                  exec_done,
  input  logic [NUM_DRIVES-1:0] drv_busy,
  output phase_e                phase_o,
  output logic                  sense_arm_o,
  output logic                  sense_first_rd_o
);
  localparam int SEL_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1;

  phase_e           phase_q;
  cmd_info_t        info_q;
  cmd_info_t        new_info;
  logic [CNT_W-1:0] remain_q;
  logic             first_q;
  logic             sel_busy;
  logic             cmd_refuse;
  logic             rslt_last_rd;

  assign new_info = cmd_lookup(dr_wdata);

  always_comb begin
    sel_busy = 1'b0;
    for (int d = 0; d < NUM_DRIVES; d++)
      if (dr_wdata[SEL_W-1:0] == SEL_W'(d)) sel_busy = drv_busy[d];
  end

  assign cmd_refuse       = (phase_q == PH_CMD) && dr_wr && first_q &&
                            info_q.chk_busy && sel_busy;
  assign sense_arm_o      = (phase_q == PH_IDLE) && dr_wr && new_info.is_sense;
  assign sense_first_rd_o = (phase_q == PH_RSLT) && dr_rd && first_q && info_q.is_sense;
  assign rslt_last_rd     = (phase_q == PH_RSLT) && dr_rd && (remain_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      info_q   <= '0;
      remain_q <= '0;
      first_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (dr_wr) begin
          info_q  <= new_info;
          first_q <= 1'b1;
          if (new_info.n_param != '0) begin
            phase_q  <= PH_CMD;
            remain_q <= new_info.n_param;
          end else begin
            phase_q  <= after_params(new_info);
            remain_q <= new_info.n_rslt;
          end
        end
        PH_CMD: begin
          if (cmd_refuse) begin
            phase_q <= PH_IDLE;
            first_q <= 1'b0;
          end else if (dr_wr) begin
            first_q <= 1'b0;
            if (remain_q == CNT_W'(1)) begin
              phase_q  <= after_params(info_q);
              remain_q <= info_q.n_rslt;
              first_q  <= 1'b1;
            end else begin
              remain_q <= remain_q - CNT_W'(1);
            end
          end
        end
        PH_EXEC: if (exec_done) begin
          phase_q  <= (info_q.n_rslt != '0) ? PH_RSLT : PH_IDLE;
          remain_q <= info_q.n_rslt;
          first_q  <= 1'b1;
        end
        PH_RSLT: if (dr_rd) begin
          first_q <= 1'b0;
          if (rslt_last_rd) phase_q  <= PH_IDLE;
          else              remain_q <= remain_q - CNT_W'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;

  // R2: last result read ends the command
  p_last_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rslt_last_rd |=> (phase_q == PH_IDLE));

  // R2: idle is left only on a data-register write
  p_idle_needs_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && !dr_wr) |=> (phase_q == PH_IDLE));

  // R5: writes and reads do not move the execution phase
  p_exec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC && !exec_done) |=> (phase_q == PH_EXEC));

  // R11: result phase waits for host reads only
  p_rslt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RSLT && !dr_rd) |=> (phase_q == PH_RSLT));

  // R8: refused command drops back to idle
  p_refuse_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_refuse |=> (phase_q == PH_IDLE));

  // R9: only one sense-clear per command
  p_one_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sense_first_rd_o |=> !sense_first_rd_o);

endmodule

// File: rtl/fdc_drive_busy.sv
module fdc_drive_busy #(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_DRIVES-1:0] seek_start,
  input  logic [NUM_DRIVES-1:0] seek_done,
  input  logic                  sense_arm,
  input  logic                  sense_clr,
  output logic [NUM_DRIVES-1:0] busy_o
);
  logic [NUM_DRIVES-1:0] busy_q;
  logic [NUM_DRIVES-1:0] done_q;
  logic [NUM_DRIVES-1:0] rep_q;
  logic [NUM_DRIVES-1:0] pick;
  logic [NUM_DRIVES-1:0] ready;

  assign ready = busy_q & done_q;

  // Lowest-numbered drive with a finished seek.
  always_comb begin
    pick = '0;
    for (int d = NUM_DRIVES - 1; d >= 0; d--)
      if (ready[d]) begin
        pick    = '0;
        pick[d] = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rep_q <= '0;
    else if (sense_arm) rep_q <= pick;
    else if (sense_clr) rep_q <= '0;
  end

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
    logic clr_here;
    assign clr_here = sense_clr && rep_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[g] <= 1'b0;
        done_q[g] <= 1'b0;
      end else if (seek_start[g]) begin
        busy_q[g] <= 1'b1;
        done_q[g] <= 1'b0;
      end else if (clr_here) begin
        busy_q[g] <= 1'b0;
        done_q[g] <= 1'b0;
      end else if (seek_done[g] && busy_q[g]) begin
        done_q[g] <= 1'b1;
      end
    end

    // R7: a seek start raises the flag
    p_start_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      seek_start[g] |=> busy_q[g]);

    // R7: flag holds until a sense clear
    p_busy_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q[g] && !clr_here) |=> busy_q[g]);

    // R9: a drive still seeking is never cleared
    p_seeking_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_clr && busy_q[g] && !done_q[g]) |=> busy_q[g]);
  end

  // R9: at most one drive reported at a time
  p_rep_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rep_q));

  assign busy_o = busy_q;

endmodule

// File: rtl/fdc_status_pack.sv
module fdc_status_pack
  import fdc_seq_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  phase_e                phase_i,
  input  logic                  dma_i,
  input  logic [NUM_DRIVES-1:0] busy_i,
  output logic [7:0]            status_o,
  output logic                  rslt_gate_o
);
  localparam int FLAG_SLOTS = 4;

  logic [FLAG_SLOTS-1:0] busy4;

  for (genvar g = 0; g < FLAG_SLOTS; g++) begin : g_slot
    if (g < NUM_DRIVES) begin : g_used
      assign busy4[g] = busy_i[g];
    end else begin : g_pad
      assign busy4[g] = 1'b0;
    end
  end

  assign status_o    = make_status(phase_i, dma_i, busy4);
  assign rslt_gate_o = (phase_i == PH_RSLT);

endmodule

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq
  import fdc_seq_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dr_wr,
  input  logic [7:0]            dr_wdata,
  input  logic                  dr_rd,
  input  logic                  dma_mode,
  input  logic                  exec_done,
  input  logic [NUM_DRIVES-1:0] seek_start,
  input  logic [NUM_DRIVES-1:0] seek_done,
  output logic [7:0]            status_o,
  output logic [1:0]            phase_o,
  output logic                  rslt_gate_o
);
  phase_e                phase;
  logic                  sense_arm;
  logic                  sense_first_rd;
  logic [NUM_DRIVES-1:0] drv_busy;

  fdc_phase_fsm #(.NUM_DRIVES(NUM_DRIVES)) u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .dr_wr            (dr_wr),
    .dr_wdata         (dr_wdata),
    .dr_rd            (dr_rd),
    .exec_done        (exec_done),
    .drv_busy         (drv_busy),
    .phase_o          (phase),
    .sense_arm_o      (sense_arm),
    .sense_first_rd_o (sense_first_rd)
  );

  fdc_drive_busy #(.NUM_DRIVES(NUM_DRIVES)) u_busy (
    .clk        (clk),
    .rst_n      (rst_n),
    .seek_start (seek_start),
    .seek_done  (seek_done),
    .sense_arm  (sense_arm),
    .sense_clr  (sense_first_rd),
    .busy_o     (drv_busy)
  );

  fdc_status_pack #(.NUM_DRIVES(NUM_DRIVES)) u_pack (
    .phase_i     (phase),
    .dma_i       (dma_mode),
    .busy_i      (drv_busy),
    .status_o    (status_o),
    .rslt_gate_o (rslt_gate_o)
  );

  assign phase_o = phase;

  // R3: no host access while executing
  p_rqm_low_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd2) |-> !status_o[7]);

  // R3: result gate implies request and outbound direction
  p_gate_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rslt_gate_o |-> (status_o[7] && status_o[6]));

  // R4: execution flag never set in DMA mode
  p_exm_dma_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode |-> !status_o[5]);

  // R5: busy whenever a command is open
  p_cb_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != 2'd0) |-> status_o[4]);

  // R10: quiet inputs keep the status steady
  p_quiet_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dr_wr && !dr_rd && !exec_done && seek_start == '0 && seek_done == '0 &&
     $stable(dma_mode)) |=> $stable(status_o));

endmodule

// File: tb/sim_fdc_phase_seq.sv
module sim_fdc_phase_seq;
  localparam int ND = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dr_wr = 1'b0;
  logic [7:0]    dr_wdata = '0;
  logic          dr_rd = 1'b0;
  logic          dma_mode = 1'b0;
  logic          exec_done = 1'b0;
  logic [ND-1:0] seek_start = '0;
  logic [ND-1:0] seek_done = '0;
  logic [7:0]    status_o;
  logic [1:0]    phase_o;
  logic          rslt_gate_o;

  logic dma_q = 1'b0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done_flag = 1'b0;

  typedef struct {
    logic [7:0] st;
    logic [1:0] ph;
    logic       gate;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  fdc_phase_seq #(.NUM_DRIVES(ND)) u0 (
    .clk(clk), .rst_n(rst_n), .dr_wr(dr_wr), .dr_wdata(dr_wdata), .dr_rd(dr_rd),
    .dma_mode(dma_mode), .exec_done(exec_done), .seek_start(seek_start),
    .seek_done(seek_done), .status_o(status_o), .phase_o(phase_o),
    .rslt_gate_o(rslt_gate_o)
  );

  // Monitor: compares the post-edge outputs to the queued expectation.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (status_o !== e.st || phase_o !== e.ph || rslt_gate_o !== e.gate) begin
        n_fail++;
        $display("FAIL %s: status=%h phase=%0d gate=%b expected status=%h phase=%0d gate=%b",
                 e.tag, status_o, phase_o, rslt_gate_o, e.st, e.ph, e.gate);
      end
    end
  end

  // Driver: one cycle of stimulus plus the expectation after that edge.
  task automatic cyc(input logic wr, input logic [7:0] wd, input logic rd,
                     input logic xd, input logic [ND-1:0] ss, input logic [ND-1:0] sd,
                     input logic [7:0] est, input logic [1:0] eph, input string tag);
    exp_t e;
    @(negedge clk);
    dr_wr = wr; dr_wdata = wd; dr_rd = rd; exec_done = xd;
    seek_start = ss; seek_done = sd; dma_mode = dma_q;
    e.st = est; e.ph = eph; e.gate = (eph == 2'd3); e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wb(input logic [7:0] d, input logic [7:0] est, input logic [1:0] eph,
                    input string tag);
    cyc(1'b1, d, 1'b0, 1'b0, '0, '0, est, eph, tag);
  endtask

  task automatic rb(input logic [7:0] est, input logic [1:0] eph, input string tag);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, '0, '0, est, eph, tag);
  endtask

  task automatic nop(input logic [7:0] est, input logic [1:0] eph, input string tag);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, '0, '0, est, eph, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    nop(8'h80, 2'd0, "R1 reset status");
    rb(8'h80, 2'd0, "R5 read in idle ignored");
    cyc(1'b0, 8'h00, 1'b0, 1'b1, '0, '0, 8'h80, 2'd0, "R11 exec_done in idle ignored");

    // Read command, non-DMA
    wb(8'h06, 8'h90, 2'd1, "R2 read opcode enters command");
    nop(8'h90, 2'd1, "R10 status steady in command");
    nop(8'h90, 2'd1, "R10 status steady again");
    wb(8'h00, 8'h90, 2'd1, "R6 read param 1");
    for (int k = 2; k <= 7; k++) wb(8'h11, 8'h90, 2'd1, "R6 read params");
    wb(8'h22, 8'h30, 2'd2, "R4 eighth param enters exec with flag");
    wb(8'h06, 8'h30, 2'd2, "R5 write in exec ignored");
    rb(8'h30, 2'd2, "R5 read in exec ignored");
    dma_q = 1'b1;
    nop(8'h10, 2'd2, "R4 flag low in DMA mode");
    dma_q = 1'b0;
    nop(8'h30, 2'd2, "R4 flag back in non-DMA");
    cyc(1'b0, 8'h00, 1'b0, 1'b1, '0, '0, 8'hD0, 2'd3, "R11 exec_done enters result");
    wb(8'h08, 8'hD0, 2'd3, "R5 write in result ignored");
    for (int k = 1; k <= 6; k++) rb(8'hD0, 2'd3, "R6 read result bytes");
    rb(8'h80, 2'd0, "R2 seventh result read returns idle");

    // Seek bookkeeping and refusal
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 4'b0010, '0, 8'h82, 2'd0, "R7 seek start drive1");
    wb(8'h0F, 8'h92, 2'd1, "R6 seek opcode");
    wb(8'h01, 8'h92, 2'd1, "R6 seek param 1");
    wb(8'h00, 8'h82, 2'd0, "R6 seek done after 2 params");
    wb(8'h06, 8'h92, 2'd1, "R8 read opcode");
    wb(8'h01, 8'h82, 2'd0, "R8 read of busy drive refused");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 4'b0100, '0, 8'h86, 2'd0, "R7 seek start drive2");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, '0, 4'b0010, 8'h86, 2'd0, "R7 flag holds after seek done");

    // Sense interrupts
    wb(8'h08, 8'hD6, 2'd3, "R6 sense goes straight to result");
    rb(8'hD4, 2'd3, "R9 first read clears drive1");
    rb(8'h84, 2'd0, "R9 second read clears nothing");
    wb(8'h08, 8'hD4, 2'd3, "R9 sense with none finished");
    rb(8'hD4, 2'd3, "R9 seeking drive kept");
    rb(8'h84, 2'd0, "R9 sense ends");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, '0, 4'b0100, 8'h84, 2'd0, "R7 drive2 seek done");
    wb(8'h08, 8'hD4, 2'd3, "R9 sense for drive2");
    rb(8'hD0, 2'd3, "R9 drive2 cleared");
    rb(8'h80, 2'd0, "R9 sense ends idle");

    // Invalid opcode
    wb(8'h1F, 8'hD0, 2'd3, "R6 invalid opcode one result");
    rb(8'h80, 2'd0, "R6 invalid result read ends");

    // Write command in DMA mode
    dma_q = 1'b1;
    wb(8'h05, 8'h90, 2'd1, "R6 write opcode");
    wb(8'h02, 8'h90, 2'd1, "R8 free drive accepted");
    for (int k = 2; k <= 7; k++) wb(8'h33, 8'h90, 2'd1, "R6 write params");
    wb(8'h44, 8'h10, 2'd2, "R4 DMA exec no flag");
    cyc(1'b0, 8'h00, 1'b0, 1'b1, '0, '0, 8'hD0, 2'd3, "R11 write exec_done");
    for (int k = 1; k <= 6; k++) rb(8'hD0, 2'd3, "R3 result direction");
    rb(8'h80, 2'd0, "R2 write ends idle");
    dma_q = 1'b0;
    nop(8'h80, 2'd0, "R10 idle steady");

    repeat (3) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule